// File: doc/BRIEF.md
# Buffered Dual-Output PWM Timer

This block is one up-counting timer that drives two PWM outputs at a common period. Each output belongs to a pair of compare channels. The even channel's match sets the output and the odd channel's match clears it. The duty cycle is the distance between the two compare values. A phase shift between the outputs comes from placing the second pair's set value at an offset, for example half the period minus the phase. A one-clock trigger pulse marks the counter reaching a chosen compare value of the second pair.

The period (the top value) and the four compare values are written through shadow buffers using plain write strobes. The top value is reloaded from its buffer at every wrap. Compare values move to the active set only after a software synchronisation request, and only for pairs whose synchronisation enable is set. The move happens at the first loading point that is enabled: counter at top, or counter at start. The counter never stops, so a running waveform can be retuned without a gap. A separate command forces both output states to an initialisation pattern. Disabled outputs show that pattern directly.

Top module: `pwm_pair_timer`

## Requirements
- R1: When the counter is below the active top value, it increments by one each clock. When it is at or above the top value, the next value is the start register. The period is top − start + 1 clocks. The start register is written at address 0 and takes effect at the next wrap.
- R2: Output p rises one clock after the counter equals compare channel 2p, and falls one clock after it equals channel 2p+1. If both values are equal, the set wins. Compare channels 0..3 are written at addresses 2..5.
- R3: A compare value greater than the active top value never matches, so its edge never occurs.
- R4: The top buffer, written at address 1, is copied to the active top at every wrap, even with no synchronisation request.
- R5: A software synchronisation request arms a transfer. The transfer fires at the first enabled loading point: counter at or above top, or counter equal to start. It copies the top buffer, and copies the compare buffers of every pair whose bit in the sync enable is 1. Pairs with the bit at 0, and all pairs while no loading point is enabled, keep their active compares.
- R6: An armed request clears when its transfer fires. Later buffer writes have no effect until a new request arrives.
- R7: trig_o pulses high one clock after the counter equals the selected compare of pair 1. The select value 0 picks channel 2 and 1 picks channel 3. A value above top gives no pulse.
- R8: An initialisation command loads bit p of init_val into output state p on the next clock, with priority over matches.
- R9: When out_en bit p is 0, pwm_o bit p equals init_val bit p.
- R10: After reset, the counter is 0, the active top is all ones, the compares are 0, the output states are 0, the trigger is 0 and no request is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address (0 start, 1 top buffer, 2..5 compare buffers) |
| wr_data_i | input | W | Write data |
| sw_sync_i | input | 1 | Software synchronisation request pulse |
| sync_en_i | input | 2 | Per-pair compare synchronisation enable |
| load_at_top_i | input | 1 | Enable the loading point at counter = top |
| load_at_start_i | input | 1 | Enable the loading point at counter = start |
| init_cmd_i | input | 1 | Output initialisation command |
| init_val_i | input | 2 | Output initialisation values |
| out_en_i | input | 2 | Per-output enable |
| trig_sel_i | input | 1 | Trigger channel select within pair 1 |
| pwm_o | output | 2 | PWM outputs |
| trig_o | output | 1 | Trigger pulse |
| cnt_o | output | W | Counter value |

## Verification
A wrong counter value appears on cnt_o in the same cycle. Because every edge position depends on the counter, it also shifts both PWM edges and the trigger within one period. A corrupt active compare or top value, or a transfer that fires early, late or twice, changes the measured high time of an output in the first full period after the transfer. The bench compares each cycle against an independent model and also measures duty arithmetically across a sweep of set and clear values. A stuck request flag shows up as a duty change after a buffer write that was made without a new request.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
    localparam int unsigned NUM_OUT = 2;
    localparam int unsigned NUM_CH  = 2 * NUM_OUT;

    typedef enum logic [2:0] {
        RA_START = 3'd0,
        RA_TOP   = 3'd1,
        RA_CMP0  = 3'd2,
        RA_CMP1  = 3'd3,
        RA_CMP2  = 3'd4,
        RA_CMP3  = 3'd5
    } reg_addr_e;
endpackage

// File: rtl/pwmt_count.sv
module pwmt_count #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] start_i,
    input  logic [W-1:0] top_i,
    output logic [W-1:0] cnt_o,
    output logic         at_top_o,
    output logic         at_start_o
);
    logic [W-1:0] cnt_d, cnt_q;

    assign at_top_o   = (cnt_q >= top_i);
    assign at_start_o = (cnt_q == start_i);
    assign cnt_o      = cnt_q;

    always_comb begin
        cnt_d = cnt_q + 1'b1;
        if (at_top_o) cnt_d = start_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R1: counting step below top
    a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q < top_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
    // R1: wrap to start register
    a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q >= top_i) |=> (cnt_q == $past(start_i)));
endmodule

// File: rtl/pwmt_edge_pair.sv
module pwmt_edge_pair #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cnt_i,
    input  logic [W-1:0] top_i,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    input  logic         init_cmd_i,
    input  logic         init_val_i,
    output logic         level_o
);
    logic level_d, level_q;
    logic set_hit, clr_hit;

    always_comb begin
        set_hit = (cnt_i == set_i) && (set_i <= top_i);
        clr_hit = (cnt_i == clr_i) && (clr_i <= top_i);
        level_d = level_q;
        if (init_cmd_i)   level_d = init_val_i;
        else if (set_hit) level_d = 1'b1;
        else if (clr_hit) level_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level_d;
    end

    assign level_o = level_q;

    // R2: set match (wins over an equal clear) raises the state
    a_r2_set_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_cmd_i && cnt_i == set_i && set_i <= top_i) |=> level_o);
    // R3: compares beyond top leave the state alone
    a_r3_no_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_cmd_i && set_i > top_i && clr_i > top_i) |=> $stable(level_o));
    // R8: initialisation command loads the state
    a_r8_init: assert property (@(posedge clk) disable iff (!rst_n)
        init_cmd_i |=> (level_o == $past(init_val_i)));
endmodule

// File: rtl/pwm_pair_timer.sv
module pwm_pair_timer
    import pwmt_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en_i,
    input  logic [2:0]   wr_addr_i,
    input  logic [W-1:0] wr_data_i,
    input  logic         sw_sync_i,
    input  logic [1:0]   sync_en_i,
    input  logic         load_at_top_i,
    input  logic         load_at_start_i,
    input  logic         init_cmd_i,
    input  logic [1:0]   init_val_i,
    input  logic [1:0]   out_en_i,
    input  logic         trig_sel_i,
    output logic [1:0]   pwm_o,
    output logic         trig_o,
    output logic [W-1:0] cnt_o
);
    typedef struct packed {
        logic [W-1:0]             start;
        logic [W-1:0]             top;
        logic [W-1:0]             top_buf;
        logic [NUM_CH-1:0][W-1:0] cmp;
        logic [NUM_CH-1:0][W-1:0] cmp_buf;
        logic                     armed;
        logic                     trig;
    } regs_t;

    regs_t        d, q;
    logic [W-1:0] cnt;
    logic         at_top, at_start, fire;
    logic [1:0]   buf_idx;
    logic [W-1:0] trig_val;
    logic [NUM_OUT-1:0] level;

    pwmt_count #(.W(W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (q.start),
        .top_i      (q.top),
        .cnt_o      (cnt),
        .at_top_o   (at_top),
        .at_start_o (at_start)
    );

    always_comb begin
        d        = q;
        fire     = q.armed && ((load_at_top_i && at_top) || (load_at_start_i && at_start));
        buf_idx  = wr_addr_i[1:0] - 2'd2;
        trig_val = trig_sel_i ? q.cmp[3] : q.cmp[2];

        if (wr_en_i) begin
            case (wr_addr_i)
                RA_START: d.start   = wr_data_i;
                RA_TOP:   d.top_buf = wr_data_i;
                RA_CMP0, RA_CMP1, RA_CMP2, RA_CMP3:
                          d.cmp_buf[buf_idx] = wr_data_i;
                default: ;
            endcase
        end

        if (at_top || fire) d.top = q.top_buf;

        if (fire) begin
            for (int p = 0; p < NUM_OUT; p++) begin
                if (sync_en_i[p]) begin
                    d.cmp[2*p]   = q.cmp_buf[2*p];
                    d.cmp[2*p+1] = q.cmp_buf[2*p+1];
                end
            end
        end

        d.armed = sw_sync_i | (q.armed & ~fire);
        d.trig  = (cnt == trig_val) && (trig_val <= q.top);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.start   <= '0;
            q.top     <= '1;
            q.top_buf <= '1;
            q.cmp     <= '0;
            q.cmp_buf <= '0;
            q.armed   <= 1'b0;
            q.trig    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    for (genvar p = 0; p < NUM_OUT; p++) begin : g_out
        pwmt_edge_pair #(.W(W)) u_pair (
            .clk        (clk),
            .rst_n      (rst_n),
            .cnt_i      (cnt),
            .top_i      (q.top),
            .set_i      (q.cmp[2*p]),
            .clr_i      (q.cmp[2*p+1]),
            .init_cmd_i (init_cmd_i),
            .init_val_i (init_val_i[p]),
            .level_o    (level[p])
        );
        assign pwm_o[p] = out_en_i[p] ? level[p] : init_val_i[p];
    end

    assign trig_o = q.trig;
    assign cnt_o  = cnt;

    // R5: active compares only move on a fired transfer
    a_r5_cmp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(q.cmp));
    // R6: request clears once its transfer fires
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !sw_sync_i) |=> !q.armed);
    // R4: top buffer reaches the active top at a wrap
    a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
        at_top |=> (q.top == $past(q.top_buf)));
    // R7: a trigger only follows an in-range counter
    a_r7_trig_range: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> ($past(cnt) <= $past(q.top)));
endmodule

// File: tb/test_pwm_pair_timer.sv
module test_pwm_pair_timer;
    import pwmt_pkg::*;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic         sw_sync = 1'b0;
    logic [1:0]   sync_en = '0;
    logic         ld_top = 1'b0, ld_start = 1'b0;
    logic         init_cmd = 1'b0;
    logic [1:0]   init_val = '0, out_en = '0;
    logic         trig_sel = 1'b0;
    logic [1:0]   pwm;
    logic         trig;
    logic [W-1:0] cnt;

    int n_vec = 0, n_err = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pwm_pair_timer #(.W(W)) i_pwm_pair_timer (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .sw_sync_i(sw_sync), .sync_en_i(sync_en),
        .load_at_top_i(ld_top), .load_at_start_i(ld_start),
        .init_cmd_i(init_cmd), .init_val_i(init_val), .out_en_i(out_en),
        .trig_sel_i(trig_sel), .pwm_o(pwm), .trig_o(trig), .cnt_o(cnt)
    );

    // reference model, from the requirements
    logic [W-1:0] m_cnt, m_start, m_top, m_topb;
    logic [W-1:0] m_cmp [4];
    logic [W-1:0] m_cmpb [4];
    logic         m_arm, m_trig;
    logic [1:0]   m_lvl;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_start = 0; m_top = '1; m_topb = '1;
            for (int i = 0; i < 4; i++) begin m_cmp[i] = 0; m_cmpb[i] = 0; end
            m_arm = 0; m_trig = 0; m_lvl = 0;
        end else begin
            logic wrap, fire;
            logic [W-1:0] sel, n_cnt, n_top;
            logic [W-1:0] n_cmp [4];
            logic [1:0] n_lvl;
            wrap = (m_cnt >= m_top);
            fire = m_arm && ((ld_top && wrap) || (ld_start && m_cnt == m_start));
            n_cnt = wrap ? m_start : m_cnt + 1'b1;
            for (int p = 0; p < 2; p++) begin
                n_lvl[p] = m_lvl[p];
                if (init_cmd) n_lvl[p] = init_val[p];
                else if (m_cnt == m_cmp[2*p] && m_cmp[2*p] <= m_top) n_lvl[p] = 1'b1;
                else if (m_cnt == m_cmp[2*p+1] && m_cmp[2*p+1] <= m_top) n_lvl[p] = 1'b0;
            end
            sel = trig_sel ? m_cmp[3] : m_cmp[2];
            m_trig = (m_cnt == sel) && (sel <= m_top);
            n_top = (wrap || fire) ? m_topb : m_top;
            for (int i = 0; i < 4; i++)
                n_cmp[i] = (fire && sync_en[i/2]) ? m_cmpb[i] : m_cmp[i];
            m_arm = sw_sync | (m_arm & ~fire);
            if (wr_en) begin
                if (wr_addr == 3'd0) m_start = wr_data;
                else if (wr_addr == 3'd1) m_topb = wr_data;
                else if (wr_addr >= 3'd2 && wr_addr <= 3'd5) m_cmpb[wr_addr-2] = wr_data;
            end
            m_cnt = n_cnt; m_top = n_top; m_lvl = n_lvl;
            for (int i = 0; i < 4; i++) m_cmp[i] = n_cmp[i];
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R1 counter", int'(cnt), int'(m_cnt));
            chk("R2 R9 outputs", int'(pwm), int'((out_en & m_lvl) | (~out_en & init_val)));
            chk("R7 trigger", int'(trig), int'(m_trig));
        end
    end

    task automatic wr(input logic [2:0] a, input int v);
        wr_en = 1; wr_addr = a; wr_data = W'(v);
        @(negedge clk); wr_en = 0;
    endtask

    task automatic pulse_sync();
        sw_sync = 1; @(negedge clk); sw_sync = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure(input int n, output int h0, output int h1, output int tc);
        h0 = 0; h1 = 0; tc = 0;
        repeat (n) begin
            @(negedge clk);
            h0 += int'(pwm[0]); h1 += int'(pwm[1]); tc += int'(trig);
        end
    endtask

    function automatic int exp_high(input int s, input int c, input int m);
        int p = m + 1;
        if (s <= m && c <= m) return (s == c) ? p : (((c - s) % p) + p) % p;
        if (s <= m) return p;
        return 0;
    endfunction

    task automatic set_cmps(input int s0, input int c0, input int s1, input int c1);
        wr(RA_CMP0, s0); wr(RA_CMP1, c0); wr(RA_CMP2, s1); wr(RA_CMP3, c1);
        pulse_sync();
        idle(18);
    endtask

    initial begin
        int h0, h1, tc, mx, lo, nt;
        string tag;
        idle(3);
        chk("R10 reset counter", int'(cnt), 0);
        chk("R10 reset outputs", int'(pwm), 0);
        chk("R10 reset trigger", int'(trig), 0);
        rst_n = 1;
        out_en = 2'b11; sync_en = 2'b11; ld_top = 1;

        // R4: top buffer applied at the wrap, no request needed
        wr(RA_TOP, 7);
        idle(260);
        mx = 0;
        repeat (16) begin @(negedge clk); if (int'(cnt) > mx) mx = int'(cnt); end
        chk("R4 top reload max count", mx, 7);

        // R2 R3 R7: sweep of set/clear values, period 8
        for (int s = 0; s <= 9; s++) begin
            for (int c = 0; c <= 9; c++) begin
                if (!(s > 7 && c > 7)) begin
                    trig_sel = logic'((s + c) & 1);
                    set_cmps(s, c, c, s);
                    measure(8, h0, h1, tc);
                    tag = (s > 7 || c > 7) ? "R3 duty pair0" : "R2 duty pair0";
                    chk(tag, h0, exp_high(s, c, 7));
                    tag = (s > 7 || c > 7) ? "R3 duty pair1" : "R2 duty pair1";
                    chk(tag, h1, exp_high(c, s, 7));
                    chk("R7 trigger count", tc, (((s + c) & 1) ? s : c) <= 7 ? 1 : 0);
                end
            end
        end

        // R5: no loading point keeps compares, then start point applies them
        trig_sel = 0;
        set_cmps(1, 5, 1, 5);
        ld_top = 0; ld_start = 0;
        wr(RA_CMP0, 3); pulse_sync(); idle(20);
        measure(8, h0, h1, tc);
        chk("R5 no loading point", h0, 4);
        ld_start = 1; idle(20);
        measure(8, h0, h1, tc);
        chk("R5 start loading point", h0, 2);

        // R6: request consumed, later write without request ignored
        wr(RA_CMP0, 0); idle(20);
        measure(8, h0, h1, tc);
        chk("R6 no second transfer", h0, 2);

        // R5: pair 1 sync disabled
        sync_en = 2'b01;
        wr(RA_CMP2, 0); pulse_sync(); idle(20);
        measure(8, h0, h1, tc);
        chk("R5 pair1 disabled", h1, 4);
        chk("R5 pair0 enabled", h0, 5);
        sync_en = 2'b11; ld_top = 1;

        // R8: compares beyond top, init command sets the states
        set_cmps(8, 9, 9, 8);
        init_val = 2'b10; init_cmd = 1; @(negedge clk); init_cmd = 0;
        chk("R8 init pattern", int'(pwm), 2);
        idle(4);
        chk("R8 init pattern held", int'(pwm), 2);
        init_val = 2'b01; init_cmd = 1; @(negedge clk); init_cmd = 0;
        chk("R8 second pattern", int'(pwm), 1);

        // R9: disabled output shows init value
        set_cmps(0, 4, 0, 4);
        out_en = 2'b01; init_val = 2'b10;
        measure(8, h0, h1, tc);
        chk("R9 disabled output", h1, 8);
        chk("R9 enabled output", h0, 4);
        out_en = 2'b11;

        // R1: start register 2 gives a period of 6
        wr(RA_START, 2); idle(10);
        lo = 255; nt = 0;
        repeat (12) begin
            @(negedge clk);
            if (int'(cnt) < lo) lo = int'(cnt);
            if (cnt == 7) nt++;
        end
        chk("R1 lowest count", lo, 2);
        chk("R1 wraps in 12 clocks", nt, 2);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end
endmodule